// File: doc/BRIEF.md
# Digit-Reversing Ping-Pong Reorder Buffer

This block sits between two radix-4 butterfly stages inside a 64-point (or 16-point) FFT engine. It takes a stream of one complex word per clock and gives back the same words in base-4 digit-reversed order, one frame later. The next butterfly stage then sees its four operands in the order it needs. It holds two banks, each one frame deep. One bank fills at consecutive addresses in arrival order. At the same time, the other bank, filled during the previous frame, is read through an address equal to the frame counter with its 2-bit digits in reverse order. The two banks trade roles each time the frame counter wraps, so the stream never stops.

The buffer controls itself. Throughput is tied to the input: an accepted input word and an emitted output word always share the same clock edge, so an idle input cycle freezes both sides and the frames stay aligned. A sync flag travels with an input word and marks it as the first word of a frame. If the buffer already expected a frame start at that word, the flag changes nothing. Otherwise the buffer restarts its framing from that word. The frame depth is set by the number of base-4 digits, `NDIG`, so a frame holds 4^NDIG words.

Top module: `quad_perm_pingpong`

## Requirements
- R1: While reset is held and right after it, out_valid and out_sof are 0 and out_data is all zeros.
- R2: After reset, no word is emitted until a whole frame of 4^NDIG words has been accepted. The first out_valid appears on the clock edge that accepts input word number 4^NDIG (counting from 0).
- R3: Output slot k of a frame carries the input word of the previous frame whose index equals k with its 2-bit digits reversed. The least significant digit of k becomes the most significant digit of the index. For NDIG=3, counter bits c5..c0 select index {c1,c0,c3,c2,c5,c4}.
- R4: Once a frame is buffered, frames fed back to back produce output on every cycle with no gap between frames.
- R5: A cycle with in_valid low leaves both the write and read positions where they were. On the next edge out_valid is 0, and the output sequence then picks up exactly where it stopped.
- R6: out_sof is 1 only together with out_valid, and only on output slot 0 of each frame.
- R7: An in_sync flag on an accepted word that already falls at frame position 0 has no effect on the output stream.
- R8: An in_sync flag on an accepted word at any other position discards both the partial frame and the buffered frame. That word becomes position 0, and no output follows until a new frame is complete.
- R9: in_sync while in_valid is low is ignored.
- R10: With NDIG=2 (16-word frames), output slot k carries the previous frame's word at index {c1,c0,c3,c2}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input word is present this cycle |
| in_sync | input | 1 | The present word begins a frame |
| in_data | input | DW | Input complex word (packed real/imaginary) |
| out_valid | output | 1 | out_data holds a reordered word |
| out_sof | output | 1 | The present output word is slot 0 of a frame |
| out_data | output | DW | Reordered output word |

## Verification
The swap edge is where two functions share a cycle. The last word of a frame goes into one bank while the final digit-reversed read empties the other, and the roles then exchange. Back-to-back frames are driven through that edge with and without idle cycles placed just around it. Every output word is compared against a model that rebuilds each frame from the requirements. A sync on a word that also triggers a read is the second collision. It is sent once at position 0, where output has to continue unchanged with a start-of-frame mark, and once at position 16. Position 16 is a restart for the 64-word instance but aligned for the 16-word instance, so one stimulus gives two different expected streams.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
    localparam int DIGIT_W = 2;

    function automatic int frame_len(input int ndig);
        return 1 << (DIGIT_W * ndig);
    endfunction
endpackage

// File: rtl/qpp_digit_rev.sv
module qpp_digit_rev #(
    parameter int NDIG = 3,
    localparam int AW = qpp_pkg::DIGIT_W * NDIG
) (
    input  logic [AW-1:0] idx_i,
    output logic [AW-1:0] addr_o
);
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign addr_o[2*g +: 2] = idx_i[2*(NDIG-1-g) +: 2];
    end
endmodule

// File: rtl/qpp_bank.sv
module qpp_bank #(
    parameter int DW = 28,
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/quad_perm_pingpong.sv
module quad_perm_pingpong #(
    parameter int NDIG = 3,
    parameter int DW   = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sync,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic [DW-1:0] out_data
);
    localparam int AW = qpp_pkg::DIGIT_W * NDIG;
    localparam int FRAME = qpp_pkg::frame_len(NDIG);
    localparam logic [AW-1:0] LAST = AW'(FRAME - 1);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          wbank;
        logic          full;
        logic          ovld;
        logic          osof;
        logic [DW-1:0] odata;
    } st_t;

    st_t q, d;

    logic          restart;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata [2];
    logic [DW-1:0] rd_word;

    assign restart = in_valid && in_sync && (q.cnt != '0);
    assign waddr   = restart ? '0 : q.cnt;

    qpp_digit_rev #(.NDIG(NDIG)) u_rev (
        .idx_i  (q.cnt),
        .addr_o (raddr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        qpp_bank #(.DW(DW), .AW(AW)) u_bank (
            .clk     (clk),
            .we_i    (in_valid && (q.wbank == b[0])),
            .waddr_i (waddr),
            .wdata_i (in_data),
            .raddr_i (raddr),
            .rdata_o (rdata[b])
        );
    end

    assign rd_word = q.wbank ? rdata[0] : rdata[1];

    always_comb begin
        d = q;
        d.ovld = 1'b0;
        d.osof = 1'b0;
        if (in_valid) begin
            if (restart) begin
                d.cnt  = AW'(1);
                d.full = 1'b0;
            end else begin
                if (q.full) begin
                    d.ovld  = 1'b1;
                    d.osof  = (q.cnt == '0);
                    d.odata = rd_word;
                end
                d.cnt = q.cnt + AW'(1);
                if (q.cnt == LAST) begin
                    d.wbank = ~q.wbank;
                    d.full  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.ovld;
    assign out_sof   = q.osof;
    assign out_data  = q.odata;

    logic [AW-1:0] frame_pos;
    logic          bank_full;
    assign frame_pos = q.cnt;
    assign bank_full = q.full;
endmodule

// File: rtl/qpp_checker.sv
module qpp_checker #(
    parameter int NDIG = 3,
    localparam int AW = qpp_pkg::DIGIT_W * NDIG
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sync,
    input logic          out_valid,
    input logic          out_sof,
    input logic [AW-1:0] frame_pos,
    input logic          bank_full
);
    AST_IDLE_FREEZES_POS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(frame_pos)); // R5

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R5

    AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R6

    AST_OUT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(bank_full)); // R2

    AST_ALIGNED_SYNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync && frame_pos == '0 && bank_full) |=> (out_valid && out_sof)); // R7

    AST_MISALIGNED_SYNC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync && frame_pos != '0) |=> (!out_valid && !bank_full)); // R8
endmodule

bind quad_perm_pingpong qpp_checker #(.NDIG(NDIG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sync   (in_sync),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .frame_pos (frame_pos),
    .bank_full (bank_full)
);

// File: tb/sim_quad_perm_pingpong.sv
module sim_quad_perm_pingpong;
    localparam int DW = 28;

    typedef struct {
        bit             v;
        bit             s;
        logic [DW-1:0]  d;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sync = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic o_v [2];
    logic o_s [2];
    logic [DW-1:0] o_d [2];

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R2";
    logic [DW-1:0] seq = 28'h100_0000;

    always #5 clk = ~clk;

    quad_perm_pingpong #(.NDIG(3), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .out_valid(o_v[0]), .out_sof(o_s[0]), .out_data(o_d[0]));

    quad_perm_pingpong #(.NDIG(2), .DW(DW)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
        .in_data(in_data), .out_valid(o_v[1]), .out_sof(o_s[1]), .out_data(o_d[1]));

    // reference model, built from the requirements
    logic [DW-1:0] cur [2][64];
    logic [DW-1:0] held [2][64];
    int  widx [2];
    int  nlen [2];
    int  ndig [2];
    bit  have [2];
    exp_t q0 [$];
    exp_t q1 [$];

    function automatic int rev(input int k, input int nd);
        int r = 0;
        for (int i = 0; i < nd; i++) r = (r << 2) | ((k >> (2*i)) & 3);
        return r;
    endfunction

    task automatic model_edge(input int i, input bit v, input bit s, input logic [DW-1:0] dv);
        exp_t e;
        e.v = 0; e.s = 0; e.d = '0;
        if (v && s && widx[i] != 0) begin
            have[i] = 0;
            cur[i][0] = dv;
            widx[i] = 1;
        end else if (v) begin
            if (have[i]) begin
                e.v = 1;
                e.s = (widx[i] == 0);
                e.d = held[i][rev(widx[i], ndig[i])];
            end
            cur[i][widx[i]] = dv;
            widx[i]++;
            if (widx[i] == nlen[i]) begin
                for (int k = 0; k < nlen[i]; k++) held[i][k] = cur[i][k];
                have[i] = 1;
                widx[i] = 0;
            end
        end
        if (i == 0) q0.push_back(e);
        else        q1.push_back(e);
    endtask

    // driver: called at a falling edge, returns at the next falling edge
    task automatic step(input bit v, input bit s);
        logic [DW-1:0] dv;
        dv = seq;
        if (v) seq = seq + 28'd1;
        in_valid = v;
        in_sync = s;
        in_data = v ? dv : 28'h0;
        @(posedge clk);
        model_edge(0, v, s, dv);
        model_edge(1, v, s, dv);
        @(negedge clk);
    endtask

    task automatic words(input int n);
        for (int k = 0; k < n; k++) step(1'b1, 1'b0);
    endtask

    task automatic compare(input int i, input exp_t e);
        string tag;
        total++;
        if (o_v[i] !== e.v) begin
            tag = (i == 1) ? "R10" : cur_req;
            bad++;
            $display("FAIL %s u%0d out_valid actual=%0b expected=%0b", tag, i, o_v[i], e.v);
        end else if (e.v && o_s[i] !== e.s) begin
            tag = (i == 1) ? "R10" : "R6";
            bad++;
            $display("FAIL %s u%0d out_sof actual=%0b expected=%0b", tag, i, o_s[i], e.s);
        end else if (e.v && o_d[i] !== e.d) begin
            tag = (i == 1) ? "R10" : "R3";
            bad++;
            $display("FAIL %s u%0d out_data actual=%h expected=%h", tag, i, o_d[i], e.d);
        end
    endtask

    // monitor: pops one expected entry per instance per cycle
    always @(negedge clk) begin
        if (q0.size() > 0) compare(0, q0.pop_front());
        if (q1.size() > 0) compare(1, q1.pop_front());
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired before the run ended");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            widx[i] = 0;
            have[i] = 0;
        end
        ndig[0] = 3; nlen[0] = 64;
        ndig[1] = 2; nlen[1] = 16;

        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        for (int i = 0; i < 2; i++) begin
            total++;
            if (o_v[i] !== 1'b0 || o_s[i] !== 1'b0 || o_d[i] !== '0) begin
                bad++;
                $display("FAIL R1 u%0d reset outputs actual=%0b/%0b/%h expected=0/0/0",
                         i, o_v[i], o_s[i], o_d[i]);
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still quiet after release with no input
        for (int i = 0; i < 2; i++) begin
            total++;
            if (o_v[i] !== 1'b0) begin
                bad++;
                $display("FAIL R1 u%0d out_valid after reset actual=%0b expected=0", i, o_v[i]);
            end
        end

        cur_req = "R2";
        words(64);
        cur_req = "R4";
        words(128);

        cur_req = "R5";
        for (int c = 0; c < 200; c++) step(((c % 5) != 2) && ((c % 7) != 3), 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        // fill up to a frame boundary for the 64-word instance
        cur_req = "R4";
        while (widx[0] != 0) step(1'b1, 1'b0);

        cur_req = "R9";
        words(5);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        words(59);

        cur_req = "R7";
        step(1'b1, 1'b1);
        words(15);

        cur_req = "R8";
        step(1'b1, 1'b1);
        words(63);
        cur_req = "R4";
        words(192);
        step(1'b0, 1'b0);
        @(negedge clk);

        // every expected entry must have been consumed
        total++;
        if (q0.size() != 0 || q1.size() != 0) begin
            bad++;
            $display("FAIL R4 scoreboard leftover actual=%0d/%0d expected=0/0", q0.size(), q1.size());
        end
        finish_run();
    end
endmodule